// File: doc/BRIEF.md
# Three-Level DMA Address Translation Walker

This block turns a 64-bit DMA address from a device into a physical address. It reads three tables from memory in turn: a region table, then a segment table, then a page table. Each request comes with a translation anchor word. The anchor supplies the region-table origin, a type field and a frame-size field. The block issues one 64-bit read at a time on a simple memory port that uses a valid/ready request and a one-cycle data return. After each read it checks the entry that comes back. It then either moves on to the next level or stops with a fault. One reserved address is set aside for interrupt messages. That address skips the walk and comes straight back, marked for the message path.

The controller is a single state machine with these states:
- `S_IDLE`: accepts a request.
- `S_RGN_REQ` / `S_RGN_WAIT`: issue the region read, then wait for its data.
- `S_SEG_REQ` / `S_SEG_WAIT`: the same for the segment level.
- `S_PG_REQ` / `S_PG_WAIT`: the same for the page level.
- `S_DONE`: presents the response for one cycle.

The transitions are:
- IDLE→DONE for the message address.
- IDLE→RGN_REQ for any other address.
- each REQ→WAIT when the memory accepts the read.
- RGN_WAIT→SEG_REQ and SEG_WAIT→PG_REQ when the entry is good.
- any WAIT→DONE on a fault.
- PG_WAIT→DONE at the end of the walk.
- DONE→IDLE.

Top module: `dma_xlate_walker`

## Requirements
- R1: The region-table origin is the anchor with its low 14 bits cleared. The three indices are DMA address bits [41:31] (region), [30:20] (segment) and [19:12] (page). Each read address is the level's origin plus the index times 8. Reads go region, then segment, then page.
- R2: A region entry is good only when its bits [3:2] are 01. The segment-table origin is that entry with its low 14 bits cleared.
- R3: A segment entry is good only when its bits [3:2] are 00. The page-table origin is that entry with its low 11 bits cleared.
- R4: On success, rsp_addr is the page entry with its low 12 bits cleared, rsp_fault is 0 and rsp_msi is 0. DMA address bits above 41 and below 12 have no effect.
- R5: The frame size is anchor bits [1:0] when the anchor type (bits [4:2]) is 4 or 5. Otherwise the frame size is 0. rsp_mask is 0xFFF for frame size 0, 0xFFFFF for frame size 1, 0x7FFFFFFF for frame size 2, and 0xFFF for frame size 3.
- R6: Address 0xFE00000000000000 makes no memory read. It returns the address unchanged, with mask 0xFFF, rsp_writable 1 and rsp_msi 1, for both reads and writes.
- R7: An entry marked invalid ends the walk with rsp_fault 1. For region and segment entries the invalid mark is bit 5; for page entries it is bit 10. rsp_level gives the level: 1 region, 2 segment, 3 page. No further read is issued.
- R8: A type mismatch at the region or segment level ends the walk with rsp_fault 2 and the level number, with no further read. Invalid takes priority over type.
- R9: Bit 9 set in any of the three entries makes the page read-only, so rsp_writable is 0. A write request to such a page returns rsp_fault 3 with rsp_level 3.
- R10: req_ready is high only in the idle state, so one walk runs at a time. While mem_req_valid is high without mem_req_ready, the request and its address hold.
- R11: rsp_valid is a single-cycle pulse. A faulted response carries rsp_addr 0, rsp_mask 0 and rsp_writable 0.
- R12: After reset the block is idle: req_ready 1, rsp_valid 0, mem_req_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | DMA address to translate |
| req_write | input | 1 | Request is a write |
| req_anchor | input | 64 | Translation anchor word |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 64 | Translated frame address |
| rsp_mask | output | 64 | Address mask for the frame |
| rsp_writable | output | 1 | Writes permitted |
| rsp_msi | output | 1 | Routed to interrupt-message path |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 type, 3 protection |
| rsp_level | output | 2 | Level of the fault (1..3) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 64 | Table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry |

## Verification
The bench builds the walker with its default field widths (11/11/8 index bits, 12-bit page shift), because the walk depends on those exact positions. Its memory model computes each table entry from the entry's address, so every index combination produces a distinct frame without any stored table. That makes it possible to sweep index extremes at every level, plus all 32 combinations of anchor type and frame size. Fault and protection marks are injected at each level in turn, and the memory stalls are varied on every read.

// File: rtl/xw_pkg.sv
package xw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RGN_REQ,
        S_RGN_WAIT,
        S_SEG_REQ,
        S_SEG_WAIT,
        S_PG_REQ,
        S_PG_WAIT,
        S_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_TYPE    = 2'd2,
        FLT_PROT    = 2'd3
    } fault_t;

    // Entry bit positions used by the table format
    localparam int TBL_INV_BIT = 5;
    localparam int PTE_INV_BIT = 10;
    localparam int PROT_BIT    = 9;
    localparam int NUM_LEVELS  = 3;

endpackage

// File: rtl/xw_index_split.sv
module xw_index_split #(
    parameter int RX_W     = 11,
    parameter int SX_W     = 11,
    parameter int PX_W     = 8,
    parameter int PG_SHIFT = 12,
    localparam int VPN_W   = RX_W + SX_W + PX_W
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [RX_W-1:0]  rx,
    output logic [SX_W-1:0]  sx,
    output logic [PX_W-1:0]  px
);
    // vpn holds DMA address bits starting at PG_SHIFT
    assign px = vpn[PX_W-1:0];
    assign sx = vpn[PX_W +: SX_W];
    assign rx = vpn[PX_W+SX_W +: RX_W];
endmodule

// File: rtl/xw_entry_chk.sv
module xw_entry_chk
    import xw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LVL    = 0,
    parameter int ALIGN  = 12
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              invalid,
    output logic              type_bad,
    output logic              prot,
    output logic [ADDR_W-1:0] next_origin
);
    assign next_origin = {entry[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
    assign prot        = entry[PROT_BIT];

    generate
        if (LVL == NUM_LEVELS - 1) begin : g_leaf
            assign invalid  = entry[PTE_INV_BIT];
            assign type_bad = 1'b0;
        end else begin : g_table
            localparam logic [1:0] WANT = (LVL == 0) ? 2'b01 : 2'b00;
            assign invalid  = entry[TBL_INV_BIT];
            assign type_bad = (entry[3:2] != WANT);
        end
    endgenerate

    logic unused_low;
    assign unused_low = ^entry[ALIGN-1:0];
endmodule

// File: rtl/xw_mask_gen.sv
module xw_mask_gen #(
    parameter int ADDR_W = 64
) (
    input  logic [4:0]        fmt,
    output logic [ADDR_W-1:0] mask
);
    logic [2:0] dtype;
    logic [1:0] fsize;

    always_comb begin
        dtype = fmt[4:2];
        fsize = (dtype == 3'd4 || dtype == 3'd5) ? fmt[1:0] : 2'd0;
        unique case (fsize)
            2'd1:    mask = ADDR_W'(64'h000F_FFFF);
            2'd2:    mask = ADDR_W'(64'h7FFF_FFFF);
            default: mask = ADDR_W'(64'h0000_0FFF);
        endcase
    end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
    import xw_pkg::*;
#(
    parameter int          ADDR_W    = 64,
    parameter int          RX_W      = 11,
    parameter int          SX_W      = 11,
    parameter int          PX_W      = 8,
    parameter int          PG_SHIFT  = 12,
    parameter int          RGN_ALIGN = 14,
    parameter int          SEG_ALIGN = 11,
    parameter logic [63:0] MSG_ADDR  = 64'hFE00_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_anchor,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [ADDR_W-1:0] rsp_mask,
    output logic              rsp_writable,
    output logic              rsp_msi,
    output logic [1:0]        rsp_fault,
    output logic [1:0]        rsp_level,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    localparam int VPN_W = RX_W + SX_W + PX_W;
    localparam int IDX_W = (RX_W > SX_W) ? ((RX_W > PX_W) ? RX_W : PX_W)
                                         : ((SX_W > PX_W) ? SX_W : PX_W);
    localparam int ENT_SHIFT = 3;

    walk_state_t state_q, state_d;

    logic [VPN_W-1:0]  vpn_q;
    logic              write_q;
    logic [4:0]        fmt_q;
    logic [ADDR_W-1:0] origin_q;
    logic              prot_q;

    logic [RX_W-1:0]   rx;
    logic [SX_W-1:0]   sx;
    logic [PX_W-1:0]   px;
    logic [IDX_W-1:0]  idx_sel;
    logic [1:0]        lvl;
    logic              is_msg;
    logic [ADDR_W-1:0] leaf_mask;

    logic [NUM_LEVELS-1:0] lv_inv, lv_type, lv_prot;
    logic [ADDR_W-1:0]     lv_next [NUM_LEVELS];

    logic cur_inv, cur_type, cur_prot, walk_stop;
    logic [ADDR_W-1:0] cur_next;

    xw_index_split #(
        .RX_W(RX_W), .SX_W(SX_W), .PX_W(PX_W), .PG_SHIFT(PG_SHIFT)
    ) u_split (
        .vpn(vpn_q), .rx(rx), .sx(sx), .px(px)
    );

    xw_mask_gen #(.ADDR_W(ADDR_W)) u_mask (
        .fmt(fmt_q), .mask(leaf_mask)
    );

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        localparam int AL = (g == 0) ? RGN_ALIGN : ((g == 1) ? SEG_ALIGN : PG_SHIFT);
        xw_entry_chk #(.ADDR_W(ADDR_W), .LVL(g), .ALIGN(AL)) u_chk (
            .entry      (mem_rsp_data),
            .invalid    (lv_inv[g]),
            .type_bad   (lv_type[g]),
            .prot       (lv_prot[g]),
            .next_origin(lv_next[g])
        );
    end

    assign is_msg = (req_addr == ADDR_W'(MSG_ADDR));

    // Level and index selection from the current state
    always_comb begin
        unique case (state_q)
            S_RGN_REQ, S_RGN_WAIT: begin lvl = 2'd0; idx_sel = IDX_W'(rx); end
            S_SEG_REQ, S_SEG_WAIT: begin lvl = 2'd1; idx_sel = IDX_W'(sx); end
            S_PG_REQ,  S_PG_WAIT:  begin lvl = 2'd2; idx_sel = IDX_W'(px); end
            default:               begin lvl = 2'd0; idx_sel = '0;         end
        endcase
    end

    assign cur_inv   = lv_inv[lvl];
    assign cur_type  = lv_type[lvl];
    assign cur_prot  = lv_prot[lvl];
    assign cur_next  = lv_next[lvl];
    assign walk_stop = cur_inv | cur_type;

    assign mem_req_addr  = origin_q + (ADDR_W'(idx_sel) << ENT_SHIFT);
    assign mem_req_valid = (state_q == S_RGN_REQ) || (state_q == S_SEG_REQ)
                        || (state_q == S_PG_REQ);
    assign req_ready     = (state_q == S_IDLE);
    assign rsp_valid     = (state_q == S_DONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = is_msg ? S_DONE : S_RGN_REQ;
            S_RGN_REQ:  if (mem_req_ready) state_d = S_RGN_WAIT;
            S_RGN_WAIT: if (mem_rsp_valid) state_d = walk_stop ? S_DONE : S_SEG_REQ;
            S_SEG_REQ:  if (mem_req_ready) state_d = S_SEG_WAIT;
            S_SEG_WAIT: if (mem_rsp_valid) state_d = walk_stop ? S_DONE : S_PG_REQ;
            S_PG_REQ:   if (mem_req_ready) state_d = S_PG_WAIT;
            S_PG_WAIT:  if (mem_rsp_valid) state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Walk context and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q        <= '0;
            write_q      <= 1'b0;
            fmt_q        <= '0;
            origin_q     <= '0;
            prot_q       <= 1'b0;
            rsp_addr     <= '0;
            rsp_mask     <= '0;
            rsp_writable <= 1'b0;
            rsp_msi      <= 1'b0;
            rsp_fault    <= FLT_NONE;
            rsp_level    <= 2'd0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    vpn_q        <= req_addr[PG_SHIFT +: VPN_W];
                    write_q      <= req_write;
                    fmt_q        <= req_anchor[4:0];
                    origin_q     <= {req_anchor[ADDR_W-1:RGN_ALIGN], {RGN_ALIGN{1'b0}}};
                    prot_q       <= 1'b0;
                    rsp_fault    <= FLT_NONE;
                    rsp_level    <= 2'd0;
                    rsp_msi      <= is_msg;
                    rsp_addr     <= is_msg ? req_addr : '0;
                    rsp_mask     <= is_msg ? ADDR_W'(64'hFFF) : '0;
                    rsp_writable <= is_msg;
                end
                S_RGN_WAIT, S_SEG_WAIT: if (mem_rsp_valid) begin
                    if (cur_inv) begin
                        rsp_fault <= FLT_INVALID;
                        rsp_level <= lvl + 2'd1;
                    end else if (cur_type) begin
                        rsp_fault <= FLT_TYPE;
                        rsp_level <= lvl + 2'd1;
                    end else begin
                        origin_q <= cur_next;
                        prot_q   <= prot_q | cur_prot;
                    end
                end
                S_PG_WAIT: if (mem_rsp_valid) begin
                    if (cur_inv) begin
                        rsp_fault <= FLT_INVALID;
                        rsp_level <= 2'd3;
                    end else if (write_q && (prot_q || cur_prot)) begin
                        rsp_fault <= FLT_PROT;
                        rsp_level <= 2'd3;
                    end else begin
                        rsp_addr     <= cur_next;
                        rsp_mask     <= leaf_mask;
                        rsp_writable <= !(prot_q || cur_prot);
                    end
                end
                S_RGN_REQ, S_SEG_REQ, S_PG_REQ, S_DONE: ;
                default: ;
            endcase
        end
    end

    logic unused_req;
    assign unused_req = ^{req_addr[PG_SHIFT-1:0], req_addr[ADDR_W-1:PG_SHIFT+VPN_W],
                          req_anchor[RGN_ALIGN-1:5]};
endmodule

// File: rtl/xw_checker.sv
module xw_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [ADDR_W-1:0] rsp_mask,
    input logic              rsp_writable,
    input logic              rsp_msi,
    input logic [1:0]        rsp_fault,
    input logic [1:0]        rsp_level,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr
);
    logic [2:0] rd_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          rd_cnt <= '0;
        else if (req_valid && req_ready)     rd_cnt <= '0;
        else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 3'd1;
    end

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10
    one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'd0 |-> rsp_addr == '0 && rsp_mask == '0 && !rsp_writable);

    // R6
    msg_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_msi |-> rd_cnt == 3'd0 && rsp_fault == 2'd0
                                 && rsp_mask == ADDR_W'(64'hFFF) && rsp_writable);

    // R7
    stop_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault == 2'd1 || rsp_fault == 2'd2) |-> rd_cnt == {1'b0, rsp_level});

    // R1
    read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= 3'd3);
endmodule

bind dma_xlate_walker xw_checker #(.ADDR_W(ADDR_W)) u_xw_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
    .rsp_writable(rsp_writable), .rsp_msi(rsp_msi), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/dma_xlate_walker_test.sv
module dma_xlate_walker_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, req_valid, req_ready, req_write, rsp_valid, rsp_writable, rsp_msi;
    logic [63:0] req_addr, req_anchor, rsp_addr, rsp_mask, mem_req_addr, mem_rsp_data;
    logic [1:0]  rsp_fault, rsp_level;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;

    dma_xlate_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_anchor(req_anchor),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
        .rsp_writable(rsp_writable), .rsp_msi(rsp_msi), .rsp_fault(rsp_fault),
        .rsp_level(rsp_level), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    localparam logic [63:0] RB  = 64'h0000_0000_0800_0000;
    localparam logic [63:0] SB  = 64'h0000_0000_2000_0000;
    localparam logic [63:0] PB  = 64'h0000_0100_0000_0000;
    localparam logic [63:0] FB  = 64'h0000_9000_0000_0000;
    localparam logic [63:0] MSG = 64'hFE00_0000_0000_0000;

    int n_chk = 0, n_fail = 0;
    int nreads, lat = 0;
    logic [63:0] ra [3];
    int inv_lvl = 0, type_lvl = 0;
    logic [2:0] prot_mask = 3'b000;

    function automatic logic [63:0] entry_at(input logic [63:0] a);
        logic [63:0] v;
        if (a >= RB && a < RB + 64'd16384) begin
            v = (SB + (((a - RB) >> 3) << 14)) | ((type_lvl == 1) ? 64'h8 : 64'h4) | 64'h3;
            if (inv_lvl == 1) v = v | 64'h20;
            if (prot_mask[0]) v = v | 64'h200;
        end else if (a >= SB && a < SB + (64'd2048 << 14)) begin
            v = (PB + (((a - SB) >> 3) << 11)) | 64'h3 | ((type_lvl == 2) ? 64'h4 : 64'h0);
            if (inv_lvl == 2) v = v | 64'h20;
            if (prot_mask[1]) v = v | 64'h200;
        end else if (a >= PB && a < PB + (64'd1 << 33)) begin
            v = (FB + (((a - PB) >> 3) << 12)) | 64'h101;
            if (inv_lvl == 3) v = v | 64'h400;
            if (prot_mask[2]) v = v | 64'h200;
        end else begin
            v = 64'hDEAD_0000_0000_0000;
        end
        return v;
    endfunction

    task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Memory model: variable stall before accept and before data
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [63:0] a;
                for (int d = 0; d < lat; d++) @(negedge clk);
                a = mem_req_addr;
                if (nreads < 3) ra[nreads] = a;
                nreads++;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int d = 0; d < (2 - lat); d++) @(negedge clk);
                mem_rsp_data  = entry_at(a);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                lat = (lat + 1) % 3;
            end
        end
    end

    task automatic walk(input logic [63:0] addr, input logic wr, input logic [63:0] anc);
        int guard = 0;
        nreads = 0;
        ra[0] = '0; ra[1] = '0; ra[2] = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_anchor = anc;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 200) begin
            n_chk++; n_fail++;
            $display("FAIL R11: no response, actual 0 expected 1");
        end
    endtask

    function automatic logic [63:0] mk_addr(input int rx, input int sx, input int px);
        return 64'h0003_FC00_0000_0ABC | (64'(rx) << 31) | (64'(sx) << 20) | (64'(px) << 12);
    endfunction

    function automatic logic [63:0] exp_frame(input int rx, input int sx, input int px);
        return FB + (((((64'(rx) << 11) + 64'(sx)) << 8) + 64'(px)) << 12);
    endfunction

    initial begin
        int rxs [4] = '{0, 1, 1023, 2047};
        int sxs [3] = '{0, 5, 2047};
        int pxs [3] = '{0, 17, 255};
        logic [63:0] anc0, em;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_anchor = '0;
        anc0 = RB | 64'h2A0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 req_ready", 64'(req_ready), 64'd1);
        check("R12 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R12 mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: index sweep
        foreach (rxs[i]) foreach (sxs[j]) foreach (pxs[k]) begin
            walk(mk_addr(rxs[i], sxs[j], pxs[k]), 1'b0, anc0);
            check("R4 frame", rsp_addr, exp_frame(rxs[i], sxs[j], pxs[k]));
            check("R1 region read addr", ra[0], RB + 64'(rxs[i]) * 8);
            check("R2 segment read addr", ra[1], SB + (64'(rxs[i]) << 14) + 64'(sxs[j]) * 8);
            check("R3 page read addr", ra[2],
                  PB + (((64'(rxs[i]) << 11) + 64'(sxs[j])) << 11) + 64'(pxs[k]) * 8);
            check("R4 status", {58'd0, rsp_fault, rsp_msi, rsp_writable, 64'(nreads) == 64'd3},
                  {58'd0, 2'd0, 1'b0, 1'b1, 1'b1});
        end

        // R5: every type / frame-size combination
        for (int t = 0; t < 8; t++) begin
            for (int f = 0; f < 4; f++) begin
                walk(mk_addr(3, 4, 5), 1'b0, RB | (64'(t) << 2) | 64'(f));
                if ((t == 4 || t == 5) && f == 1)      em = 64'hF_FFFF;
                else if ((t == 4 || t == 5) && f == 2) em = 64'h7FFF_FFFF;
                else                                   em = 64'hFFF;
                check("R5 mask", rsp_mask, em);
            end
        end

        // R6: message address bypass, read and write
        for (int w = 0; w < 2; w++) begin
            walk(MSG, w[0], anc0);
            check("R6 addr", rsp_addr, MSG);
            check("R6 mask", rsp_mask, 64'hFFF);
            check("R6 flags", {61'd0, rsp_msi, rsp_writable, rsp_fault == 2'd0}, 64'h7);
            check("R6 no reads", 64'(nreads), 64'd0);
        end

        // R7: invalid at each level
        for (int l = 1; l <= 3; l++) begin
            inv_lvl = l;
            walk(mk_addr(9, 10, 11), 1'b0, anc0);
            check("R7 fault code", 64'(rsp_fault), 64'd1);
            check("R7 level", 64'(rsp_level), 64'(l));
            check("R7 reads", 64'(nreads), 64'(l));
            check("R11 faulted output", {rsp_addr, 63'd0, rsp_writable}, '0);
        end
        inv_lvl = 0;

        // R8: type mismatch, and invalid priority
        for (int l = 1; l <= 2; l++) begin
            type_lvl = l;
            walk(mk_addr(9, 10, 11), 1'b1, anc0);
            check("R8 fault code", 64'(rsp_fault), 64'd2);
            check("R8 level", 64'(rsp_level), 64'(l));
            check("R8 reads", 64'(nreads), 64'(l));
            inv_lvl = l;
            walk(mk_addr(9, 10, 11), 1'b0, anc0);
            check("R8 invalid priority", 64'(rsp_fault), 64'd1);
            inv_lvl = 0;
        end
        type_lvl = 0;

        // R9: protection at each level
        for (int l = 0; l < 3; l++) begin
            prot_mask = 3'b001 << l;
            walk(mk_addr(100, 200, 30), 1'b0, anc0);
            check("R9 read-only", {62'd0, rsp_writable, rsp_fault != 2'd0}, 64'd0);
            check("R9 read frame", rsp_addr, exp_frame(100, 200, 30));
            walk(mk_addr(100, 200, 30), 1'b1, anc0);
            check("R9 write fault", {60'd0, rsp_fault, rsp_level}, {60'd0, 2'd3, 2'd3});
            check("R9 write reads", 64'(nreads), 64'd3);
        end
        prot_mask = 3'b000;
        walk(mk_addr(100, 200, 30), 1'b1, anc0);
        check("R9 unprotected write", {62'd0, rsp_writable, rsp_fault != 2'd0}, 64'd2);

        // R10: busy while walking
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk_addr(1, 2, 3); req_write = 1'b0; req_anchor = anc0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 not ready during walk", 64'(req_ready), 64'd0);
        while (!rsp_valid) @(negedge clk);
        @(negedge clk);
        // R11 pulse
        check("R11 pulse ends", 64'(rsp_valid), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule